// File: doc/BRIEF.md
# Block Move Engine

The engine runs a single block-copy instruction for an instruction sequencer. It takes an instruction word, a source and a destination address, and two space-select bits. It then copies a byte count from source to destination over one request/grant bus master port. Data is staged in an internal byte FIFO. The engine reads a burst from the source until the burst is complete, then drains that burst to the destination, and repeats until the count is exhausted. When the count is exhausted it pulses a request for the sequencer to fetch its next instruction.

Before any bus activity, the instruction is screened. Mismatched low address bits or non-zero reserved bits abort the instruction and raise a sticky illegal-instruction flag, which software clears. The source and destination pointers are kept in two private working registers, and no indirect address is ever formed. A separate context pointer register, owned by the sequencer, is never disturbed by a move.

Top module: `blkmove_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `bus_req`, `fetch_next` and `illegal_irq` are all 0.
- R2: A legal `start` copies N bytes, where N is `instr[23:0]` and is at most 16 MB. The copy runs from `src_addr` upward to `dst_addr` upward. One byte moves on each cycle where `bus_req` and `bus_gnt` are both high, and read data is taken in that same cycle.
- R3: While reading, `bus_io` equals the `src_io` value captured at `start`. While writing, it equals the captured `dst_io`. In both cases 1 means I/O space and 0 means memory space. `bus_we` is 1 only during write beats.
- R4: If `src_addr[1:0]` differs from `dst_addr[1:0]`, `illegal_irq` is 1 in the cycle after `start`. No bus request is made, no byte is moved, and `fetch_next` stays 0.
- R5: If any of `instr[28:25]` is 1, the instruction is rejected exactly as in R4.
- R6: Each burst reads min(FIFO_DEPTH, remaining) bytes and then writes that same number of bytes. A read beat never follows a write beat within a burst. With the default FIFO_DEPTH of 8, no run of consecutive read beats is longer than 8.
- R7: A legal `start` with a zero count makes no bus request. It pulses `fetch_next` in the cycle after `start`.
- R8: `fetch_next` is a single-cycle pulse. It comes in the cycle after the last write beat and is issued exactly once per completed instruction.
- R9: `illegal_irq` stays 1 until `irq_clr` is sampled high. If a new rejection and `irq_clr` fall in the same cycle, the flag ends up 1.
- R10: `ctx_q` loads `ctx_wdata` when `ctx_wr` is high. A move leaves `ctx_q` unchanged.
- R11: A `start` that arrives while `busy` is 1 is ignored.
- R12: While `bus_req` is high and `bus_gnt` is low, `bus_req`, `bus_addr` and `bus_we` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the instruction when idle |
| instr | input | 32 | Instruction word: count in [23:0], reserved [28:25] |
| src_addr | input | 32 | Source start address |
| dst_addr | input | 32 | Destination start address |
| src_io | input | 1 | Source in I/O space when 1 |
| dst_io | input | 1 | Destination in I/O space when 1 |
| irq_clr | input | 1 | Clears the illegal-instruction flag |
| ctx_wr | input | 1 | Load enable for the context pointer |
| ctx_wdata | input | 32 | Context pointer load value |
| ctx_q | output | 32 | Context pointer |
| bus_req | output | 1 | Bus beat request |
| bus_gnt | input | 1 | Bus beat accepted this cycle |
| bus_we | output | 1 | 1 for write beat, 0 for read beat |
| bus_io | output | 1 | Address space of the beat |
| bus_addr | output | 32 | Beat byte address |
| bus_wdata | output | 8 | Write byte |
| bus_rdata | input | 8 | Read byte, valid in the granted cycle |
| fetch_next | output | 1 | Request to fetch the next instruction |
| illegal_irq | output | 1 | Sticky illegal-instruction interrupt |
| busy | output | 1 | Instruction in progress |

## Verification
Software clearing the sticky interrupt and the engine setting it can fall in the same cycle. The bench provokes this by holding `irq_clr` high in the very cycle it launches a misaligned instruction. The flag must read 1 afterwards, and a plain clear alone must then bring it to 0. A second overlap is a new `start` arriving while a multi-burst copy under a stalling grant is still running. That start is judged by confirming that the second copy's destination bytes are untouched and that only one fetch pulse appears.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;
  localparam int CNT_W    = 24;
  localparam int RES_LO   = 25;
  localparam int RES_HI   = 28;
  localparam int ALIGN_W  = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } mv_state_e;
endpackage

// File: rtl/blkmove_check.sv
module blkmove_check
  import blkmove_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [ADDR_W-1:0]  dst_addr,
  output logic               illegal,
  output logic [CNT_W-1:0]   count
);
  logic misaligned;
  logic res_set;

  always_comb begin
    misaligned = (src_addr[ALIGN_W-1:0] != dst_addr[ALIGN_W-1:0]);
    res_set    = |instr[RES_HI:RES_LO];
    illegal    = misaligned | res_set;
    count      = instr[CNT_W-1:0];
  end
endmodule

// File: rtl/blkmove_fifo.sv
module blkmove_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic              empty,
  output logic              full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) ptr_inc = '0;
    else                     ptr_inc = p + PW'(1);
  endfunction

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = ptr_inc(wp_q);
    if (pop)  rp_d = ptr_inc(rp_q);
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wdata;
  end

  assign rdata = mem_q[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // R6: staging never overruns or underruns
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
  import blkmove_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              illegal,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic              src_io,
  input  logic              dst_io,
  input  logic              irq_clr,
  input  logic              bus_gnt,
  input  logic              fifo_empty,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_io,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              fifo_push,
  output logic              fifo_pop,
  output logic              fetch_next,
  output logic              illegal_irq,
  output logic              busy
);
  localparam int BLEN_W = $clog2(DEPTH + 1);

  mv_state_e          state_q, state_d;
  logic [ADDR_W-1:0]  src_q, src_d, dst_q, dst_d;
  logic               sio_q, sio_d, dio_q, dio_d;
  logic [CNT_W-1:0]   rem_q, rem_d;
  logic [BLEN_W-1:0]  blen_q, blen_d, beat_q, beat_d;
  logic               irq_q, irq_d;
  logic               last_beat;

  function automatic logic [BLEN_W-1:0] burst_of(input logic [CNT_W-1:0] r);
    if (r > CNT_W'(DEPTH)) burst_of = BLEN_W'(DEPTH);
    else                   burst_of = r[BLEN_W-1:0];
  endfunction

  assign last_beat = (beat_q == blen_q - BLEN_W'(1));

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    sio_d   = sio_q;
    dio_d   = dio_q;
    rem_d   = rem_q;
    blen_d  = blen_q;
    beat_d  = beat_q;
    irq_d   = irq_q;
    if (irq_clr) irq_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (illegal) begin
            irq_d = 1'b1;
          end else begin
            src_d   = src_addr;
            dst_d   = dst_addr;
            sio_d   = src_io;
            dio_d   = dst_io;
            rem_d   = count;
            blen_d  = burst_of(count);
            beat_d  = '0;
            state_d = (count == '0) ? ST_DONE : ST_READ;
          end
        end
      end
      ST_READ: begin
        if (bus_gnt) begin
          src_d = src_q + ADDR_W'(1);
          if (last_beat) begin
            beat_d  = '0;
            state_d = ST_WRITE;
          end else begin
            beat_d = beat_q + BLEN_W'(1);
          end
        end
      end
      ST_WRITE: begin
        if (bus_gnt) begin
          dst_d = dst_q + ADDR_W'(1);
          rem_d = rem_q - CNT_W'(1);
          if (last_beat) begin
            beat_d = '0;
            if (rem_q == CNT_W'(1)) begin
              state_d = ST_DONE;
            end else begin
              blen_d  = burst_of(rem_q - CNT_W'(1));
              state_d = ST_READ;
            end
          end else begin
            beat_d = beat_q + BLEN_W'(1);
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      sio_q   <= 1'b0;
      dio_q   <= 1'b0;
      rem_q   <= '0;
      blen_q  <= '0;
      beat_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      sio_q   <= sio_d;
      dio_q   <= dio_d;
      rem_q   <= rem_d;
      blen_q  <= blen_d;
      beat_q  <= beat_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    bus_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
    bus_we      = (state_q == ST_WRITE);
    bus_io      = bus_we ? dio_q : sio_q;
    bus_addr    = bus_we ? dst_q : src_q;
    fifo_push   = (state_q == ST_READ) && bus_gnt;
    fifo_pop    = (state_q == ST_WRITE) && bus_gnt;
    fetch_next  = (state_q == ST_DONE);
    illegal_irq = irq_q;
    busy        = (state_q != ST_IDLE);
  end

  // R4 / R5: rejected instruction raises the flag and never reaches the bus
  a_r4_reject_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && illegal) |=> (illegal_irq && !bus_req && !fetch_next));
  // R7: zero count finishes without a bus request
  a_r7_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !illegal && count == '0) |=> (fetch_next && !bus_req));
  // R8: completion is a single pulse
  a_r8_fetch_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_next |=> !fetch_next);
  // R9: flag holds until cleared
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_irq && !irq_clr) |=> illegal_irq);
  // R12: stalled beat is held
  a_r12_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
  // R6: a write beat always has a staged byte
  a_r6_write_staged: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> !fifo_empty);
endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSTR_W    = 32,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [ADDR_W-1:0]  src_addr,
  input  logic [ADDR_W-1:0]  dst_addr,
  input  logic               src_io,
  input  logic               dst_io,
  input  logic               irq_clr,
  input  logic               ctx_wr,
  input  logic [ADDR_W-1:0]  ctx_wdata,
  output logic [ADDR_W-1:0]  ctx_q,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               bus_we,
  output logic               bus_io,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  input  logic [DATA_W-1:0]  bus_rdata,
  output logic               fetch_next,
  output logic               illegal_irq,
  output logic               busy
);
  logic             illegal;
  logic [CNT_W-1:0] count;
  logic             fifo_push, fifo_pop, fifo_empty, fifo_full;
  logic [ADDR_W-1:0] ctx_r;

  blkmove_check #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) check_i (
    .instr    (instr),
    .src_addr (src_addr),
    .dst_addr (dst_addr),
    .illegal  (illegal),
    .count    (count)
  );

  blkmove_ctrl #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .illegal     (illegal),
    .count       (count),
    .src_addr    (src_addr),
    .dst_addr    (dst_addr),
    .src_io      (src_io),
    .dst_io      (dst_io),
    .irq_clr     (irq_clr),
    .bus_gnt     (bus_gnt),
    .fifo_empty  (fifo_empty),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_io      (bus_io),
    .bus_addr    (bus_addr),
    .fifo_push   (fifo_push),
    .fifo_pop    (fifo_pop),
    .fetch_next  (fetch_next),
    .illegal_irq (illegal_irq),
    .busy        (busy)
  );

  blkmove_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .wdata (bus_rdata),
    .pop   (fifo_pop),
    .rdata (bus_wdata),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  // R10: context pointer is touched only by its own load enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx_r <= '0;
    else if (ctx_wr) ctx_r <= ctx_wdata;
  end
  assign ctx_q = ctx_r;

  // R1: no bus activity while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
endmodule

// File: tb/blkmove_engine_tb.sv
module blkmove_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, src_io, dst_io, irq_clr, ctx_wr, bus_gnt;
  logic [31:0] instr, src_addr, dst_addr, ctx_wdata, ctx_q, bus_addr;
  logic        bus_req, bus_we, bus_io, fetch_next, illegal_irq, busy;
  logic [7:0]  bus_wdata, bus_rdata;

  logic [7:0]  mem   [256];
  logic [7:0]  iomem [256];
  int checks = 0, fails = 0, cyc = 0;
  int fetch_cnt = 0, beat_cnt = 0, rd_run = 0, rd_run_max = 0;
  bit stall_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkmove_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_io(src_io), .dst_io(dst_io),
    .irq_clr(irq_clr), .ctx_wr(ctx_wr), .ctx_wdata(ctx_wdata), .ctx_q(ctx_q),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we), .bus_io(bus_io),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fetch_next(fetch_next), .illegal_irq(illegal_irq), .busy(busy)
  );

  assign bus_rdata = bus_io ? iomem[bus_addr[7:0]] : mem[bus_addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fetch_next) fetch_cnt <= fetch_cnt + 1;
    if (bus_req && bus_gnt) begin
      beat_cnt <= beat_cnt + 1;
      if (bus_we) begin
        rd_run <= 0;
        if (bus_io) iomem[bus_addr[7:0]] <= bus_wdata;
        else        mem[bus_addr[7:0]]   <= bus_wdata;
      end else begin
        rd_run <= rd_run + 1;
        if (rd_run + 1 > rd_run_max) rd_run_max <= rd_run + 1;
      end
    end
  end

  always @(negedge clk) bus_gnt = stall_mode ? ((cyc % 3) != 0) : 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) if (cyc == 150000) begin
    checks++; fails++;
    $display("FAIL watchdog: actual running expected done");
    summary();
  end

  function automatic logic [31:0] mk_instr(input logic [3:0] res, input logic [23:0] n);
    return {3'b110, res, 1'b0, n};
  endfunction

  task automatic fill();
    for (int i = 0; i < 256; i++) begin
      mem[i]   = 8'(i * 7 + 3);
      iomem[i] = 8'(i ^ 8'h5A);
    end
  endtask

  task automatic clear_counts();
    fetch_cnt = 0; beat_cnt = 0; rd_run = 0; rd_run_max = 0;
  endtask

  task automatic launch(input logic [31:0] ins, input logic [31:0] s, input logic [31:0] d,
                        input logic sio, input logic dio);
    @(negedge clk);
    instr = ins; src_addr = s; dst_addr = d; src_io = sio; dst_io = dio; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 fetch_next", fetch_next, 0);
    chk("R1 illegal_irq", illegal_irq, 0);
  endtask

  task automatic t_basic();
    int bad = 0;
    fill(); clear_counts();
    launch(mk_instr(4'h0, 24'd5), 32'h10, 32'h40, 1'b0, 1'b0);
    wait_idle();
    for (int i = 0; i < 5; i++) if (mem[8'h40 + i] !== 8'(((8'h10 + i) * 7) + 3)) bad++;
    chk("R2 short copy bytes", bad, 0);
    chk("R2 short copy no spill", mem[8'h45], 8'((8'h45 * 7) + 3));
    chk("R8 one fetch pulse", fetch_cnt, 1);
    chk("R2 beat count", beat_cnt, 10);
  endtask

  task automatic t_multi();
    int bad = 0;
    fill(); clear_counts(); stall_mode = 1'b1;
    launch(mk_instr(4'h0, 24'd20), 32'h21, 32'h85, 1'b0, 1'b0);
    // R11: a second start during the move must be ignored
    @(negedge clk);
    instr = mk_instr(4'h0, 24'd4); src_addr = 32'h00; dst_addr = 32'hC0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle(); stall_mode = 1'b0;
    for (int i = 0; i < 20; i++) if (mem[8'h85 + i] !== 8'(((8'h21 + i) * 7) + 3)) bad++;
    chk("R2 R12 multi-burst copy under stall", bad, 0);
    chk("R6 longest read run", rd_run_max, 8);
    chk("R8 one fetch pulse multi", fetch_cnt, 1);
    chk("R11 ignored start left dst", mem[8'hC0], 8'((8'hC0 * 7) + 3));
  endtask

  task automatic t_spaces();
    int bad = 0;
    fill(); clear_counts();
    launch(mk_instr(4'h0, 24'd8), 32'h30, 32'hA0, 1'b1, 1'b0);
    wait_idle();
    for (int i = 0; i < 8; i++) if (mem[8'hA0 + i] !== 8'((8'h30 + i) ^ 8'h5A)) bad++;
    chk("R3 io to mem", bad, 0);
    chk("R3 io dst untouched", iomem[8'hA0], 8'(8'hA0 ^ 8'h5A));
    bad = 0;
    launch(mk_instr(4'h0, 24'd6), 32'h50, 32'h10, 1'b0, 1'b1);
    wait_idle();
    for (int i = 0; i < 6; i++) if (iomem[8'h10 + i] !== 8'(((8'h50 + i) * 7) + 3)) bad++;
    chk("R3 mem to io", bad, 0);
  endtask

  task automatic t_zero();
    fill(); clear_counts();
    launch(mk_instr(4'h0, 24'd0), 32'h10, 32'h20, 1'b0, 1'b0);
    chk("R7 zero count fetch next cycle", fetch_next, 1);
    chk("R7 zero count no req", bus_req, 0);
    wait_idle();
    chk("R7 zero count no beats", beat_cnt, 0);
  endtask

  task automatic t_illegal();
    fill(); clear_counts();
    launch(mk_instr(4'h0, 24'd4), 32'h01, 32'h02, 1'b0, 1'b0);
    chk("R4 misalign irq", illegal_irq, 1);
    chk("R4 misalign not busy", busy, 0);
    @(negedge clk);
    chk("R4 misalign no beats", beat_cnt, 0);
    chk("R4 misalign no fetch", fetch_cnt, 0);
    chk("R9 sticky", illegal_irq, 1);
    @(negedge clk); irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R9 cleared", illegal_irq, 0);
    launch(mk_instr(4'h4, 24'd4), 32'h10, 32'h20, 1'b0, 1'b0);
    chk("R5 reserved bit irq", illegal_irq, 1);
    @(negedge clk);
    chk("R5 reserved no beats", beat_cnt, 0);
    chk("R5 reserved dst untouched", mem[8'h20], 8'((8'h20 * 7) + 3));
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    // R9: set and clear in the same cycle, set wins
    @(negedge clk);
    instr = mk_instr(4'h0, 24'd4); src_addr = 32'h3; dst_addr = 32'h0;
    start = 1'b1; irq_clr = 1'b1;
    @(negedge clk); start = 1'b0; irq_clr = 1'b0;
    chk("R9 set wins over clear", illegal_irq, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_ctx();
    @(negedge clk); ctx_wdata = 32'hCAFE_0123; ctx_wr = 1'b1;
    @(negedge clk); ctx_wr = 1'b0;
    chk("R10 ctx load", ctx_q, 32'hCAFE_0123);
    fill();
    launch(mk_instr(4'h0, 24'd12), 32'h60, 32'hE0, 1'b0, 1'b0);
    wait_idle();
    chk("R10 ctx kept across move", ctx_q, 32'hCAFE_0123);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; irq_clr = 1'b0; ctx_wr = 1'b0; ctx_wdata = '0;
    instr = '0; src_addr = '0; dst_addr = '0; src_io = 1'b0; dst_io = 1'b0; bus_gnt = 1'b1;
    fill();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_multi();
    t_spaces();
    t_zero();
    t_illegal();
    t_ctx();
    summary();
  end
endmodule